// File: doc/BRIEF.md
# Bus Claim and Priority Chain Handshake

This block lets one device claim a shared bus. When the device has a service request pending and raises a DMA request while no other device is requesting, the block waits a fixed settling time and then drives an active-low bus-request strobe. The bus controller answers by raising a shared busy line, and the block records this as an acknowledgement.

A priority pulse travels from device to device along a chain. An idle or not-yet-acknowledged device passes the pulse straight on to its downstream neighbour. An acknowledged device stops passing it on. It uses the pulse to mark itself selected and to start its transfer phase, and it withdraws its bus request in the same step. When the service request goes away, every flag clears and the device passes the pulse on again.

The busy line and the incoming pulse are asynchronous. Each goes through a synchronizer, and the pulse is detected by its rising edge. The forwarding path is a purely combinational gate, so a passing pulse gains no delay.

Top module: `bus_claim_ctrl`

## Requirements
- R1: While the block is not acknowledged, `prio_out` equals `prio_in` with no clock delay. This includes the time when no service request is pending.
- R2: `drv_en` is 1 in the cycle after `svc_req` is sampled 1, and 0 in the cycle after it is sampled 0.
- R3: A bus request is issued only when all three hold: `svc_req` is 1, `dma_req` is 1, and the synchronized `sel_busy_in` is 0. If any of them fails, the settling count restarts.
- R4: The request is raised only after the qualifying condition has held for DELAY_CYCLES consecutive clock edges (default 10 edges, i.e. 50 ns at 200 MHz). A condition that is held for fewer edges never raises it.
- R5: While the request flag is set, `req_n` is 0. Otherwise `req_n` is 1.
- R6: While the request flag is set and the synchronized `sel_busy_in` is 1, the block sets an acknowledged flag. While that flag is set, `prio_out` is held at 0 whatever `prio_in` does.
- R7: A rising edge of the synchronized `prio_in` seen while acknowledged sets `selected` and `xfer_on` and clears the request, so `req_n` returns to 1. These outputs change three clock edges after `prio_in` rises.
- R8: When `svc_req` is sampled 0, the acknowledged flag, `selected` and `xfer_on` clear at that edge, and pass-through of the priority pulse resumes.
- R9: Sampling `svc_req` at 0 also withdraws a request that is still pending, so `req_n` returns to 1 at that edge.
- R10: While acknowledged, the block raises no new request, even if `dma_req` stays high.
- R11: After reset, `req_n` is 1 and `drv_en`, `selected` and `xfer_on` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_req | input | 1 | Device service request pending |
| dma_req | input | 1 | Device asks for a direct memory transfer |
| sel_busy_in | input | 1 | Shared select-busy line from the bus controller (asynchronous) |
| prio_in | input | 1 | Priority pulse from the upstream device (asynchronous) |
| req_n | output | 1 | Active-low bus-request strobe |
| prio_out | output | 1 | Priority pulse forwarded to the downstream device |
| drv_en | output | 1 | Enable for the bus drivers and receivers |
| selected | output | 1 | Device holds the bus |
| xfer_on | output | 1 | Transfer phase active |

## Verification
The results fall due at different times:
- `prio_out` follows `prio_in` in the same cycle.
- `drv_en`, and the clearing of all flags after `svc_req` drops, appear one edge after the input is sampled.
- `req_n` falls exactly DELAY_CYCLES edges after the condition starts to hold.
- The acknowledgement and the grant each take three edges: two synchronizer stages, then the flag register.

The bench drives and samples only on falling clock edges and counts rising edges explicitly to reach each due cycle. The settling delay is swept over every hold length from 1 to DELAY_CYCLES+2 edges. The bench checks that the request appears exactly when the hold length reaches the threshold.

// File: rtl/bus_claim_pkg.sv
package bus_claim_pkg;

   // Handshake flags held by the claim controller
   typedef struct packed {
      logic req;    // bus request outstanding
      logic ack;    // controller answered the request
      logic xfer;   // transfer phase running
      logic sel;    // device owns the bus
   } claim_flags_t;

   localparam claim_flags_t CLAIM_IDLE = '{req: 1'b0, ack: 1'b0, xfer: 1'b0, sel: 1'b0};

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction

endpackage

// File: rtl/brq_sync.sv
module brq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad
      $error("brq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/brq_edge.sv
module brq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic rise
);
   logic d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_q <= 1'b0;
      else        d_q <= d;
   end

   assign rise = d & ~d_q;
endmodule

// File: rtl/brq_hold_timer.sv
module brq_hold_timer #(
   parameter int unsigned HOLD = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic done
);
   import bus_claim_pkg::*;

   localparam int unsigned CW = cnt_width(HOLD);

   if (HOLD < 1) begin : g_bad
      $error("brq_hold_timer: HOLD must be at least 1");
   end

   if (HOLD == 1) begin : g_direct
      assign done = arm;
   end else begin : g_count
      logic [CW-1:0] cnt;
      logic          at_end;

      assign at_end = (cnt == CW'(HOLD - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       cnt <= '0;
         else if (!arm)    cnt <= '0;
         else if (!at_end) cnt <= cnt + 1'b1;
      end

      assign done = arm & at_end;

      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= CW'(HOLD - 1));  // R4
   end
endmodule

// File: rtl/bus_claim_ctrl.sv
module bus_claim_ctrl #(
   parameter int unsigned DELAY_CYCLES = 10,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic svc_req,
   input  logic dma_req,
   input  logic sel_busy_in,
   input  logic prio_in,
   output logic req_n,
   output logic prio_out,
   output logic drv_en,
   output logic selected,
   output logic xfer_on
);
   import bus_claim_pkg::*;

   if (DELAY_CYCLES < 1) begin : g_bad_delay
      $error("bus_claim_ctrl: DELAY_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bus_claim_ctrl: SYNC_STAGES must be at least 2");
   end

   logic         busy_s;
   logic         prio_s;
   logic         prio_rise;
   logic         claim_arm;
   logic         claim_due;
   logic         drv_q;
   claim_flags_t fl;

   brq_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
      .clk(clk), .rst_n(rst_n), .d(sel_busy_in), .q(busy_s));

   brq_sync #(.STAGES(SYNC_STAGES)) u_prio_sync (
      .clk(clk), .rst_n(rst_n), .d(prio_in), .q(prio_s));

   brq_edge u_prio_edge (
      .clk(clk), .rst_n(rst_n), .d(prio_s), .rise(prio_rise));

   // Qualifying condition for a new bus request
   assign claim_arm = svc_req & dma_req & ~busy_s & ~fl.req & ~fl.ack;

   brq_hold_timer #(.HOLD(DELAY_CYCLES)) u_settle (
      .clk(clk), .rst_n(rst_n), .arm(claim_arm), .done(claim_due));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl <= CLAIM_IDLE;
      end else if (!svc_req) begin
         fl <= CLAIM_IDLE;
      end else begin
         if (claim_due)
            fl.req <= 1'b1;
         if (fl.req && busy_s)
            fl.ack <= 1'b1;
         if (fl.ack && prio_rise) begin
            fl.sel  <= 1'b1;
            fl.xfer <= 1'b1;
            fl.req  <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv_q <= 1'b0;
      else        drv_q <= svc_req;
   end

   assign req_n    = ~fl.req;
   assign prio_out = prio_in & ~fl.ack;
   assign drv_en   = drv_q;
   assign selected = fl.sel;
   assign xfer_on  = fl.xfer;

   AST_REQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_n) |-> $past(svc_req && dma_req && !busy_s));  // R3
   AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !svc_req |=> (!selected && !xfer_on && req_n && !fl.ack));  // R8
   AST_GRANT_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(selected) |-> (req_n && xfer_on && $past(fl.ack)));  // R7
   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl.ack) |-> $past(!req_n && busy_s));  // R6
   AST_NO_REQ_WHILE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fl.ack) && fl.ack) |-> !$fell(req_n));  // R10
endmodule

// File: tb/test_bus_claim_ctrl.sv
`timescale 1ns/1ps
module test_bus_claim_ctrl;
   localparam int D = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic svc_req = 1'b0, dma_req = 1'b0, sel_busy_in = 1'b0, prio_in = 1'b0;
   logic req_n, prio_out, drv_en, selected, xfer_on;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   bus_claim_ctrl #(.DELAY_CYCLES(D), .SYNC_STAGES(2)) i_bus_claim_ctrl (
      .clk(clk), .rst_n(rst_n), .svc_req(svc_req), .dma_req(dma_req),
      .sel_busy_in(sel_busy_in), .prio_in(prio_in), .req_n(req_n),
      .prio_out(prio_out), .drv_en(drv_en), .selected(selected), .xfer_on(xfer_on));

   task automatic chk(input string tag, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_all();
      svc_req = 0; dma_req = 0; sel_busy_in = 0; prio_in = 0;
      edges(3);
   endtask

   initial begin
      edges(3);
      rst_n = 1'b1;
      edges(1);
      // R11 reset state
      chk("R11 req_n", req_n, 1'b1);
      chk("R11 drv_en", drv_en, 1'b0);
      chk("R11 selected", selected, 1'b0);
      chk("R11 xfer_on", xfer_on, 1'b0);

      // R1 pass-through, idle and pending-but-unacked
      prio_in = 1; #1 chk("R1 idle fwd high", prio_out, 1'b1);
      prio_in = 0; #1 chk("R1 idle fwd low", prio_out, 1'b0);
      edges(1);
      svc_req = 1;
      edges(1);
      chk("R2 drv_en on", drv_en, 1'b1);
      prio_in = 1; #1 chk("R1 unacked fwd", prio_out, 1'b1);
      edges(4);
      chk("R6 no select without ack", selected, 1'b0);
      prio_in = 0;
      svc_req = 0;
      edges(1);
      chk("R2 drv_en off", drv_en, 1'b0);
      idle_all();

      // R4 sweep of hold length
      for (int k = 1; k <= D + 2; k++) begin
         svc_req = 1; dma_req = 1;
         edges(k);
         dma_req = 0;
         edges(1);
         chk($sformatf("R4 hold=%0d", k), req_n, (k >= D) ? 1'b0 : 1'b1);
         svc_req = 0;
         edges(1);
         chk($sformatf("R9 withdraw hold=%0d", k), req_n, 1'b1);
         idle_all();
      end

      // R3 gating by busy line, by missing DMA, by missing service
      sel_busy_in = 1; svc_req = 1; dma_req = 1;
      edges(D + 4);
      chk("R3 busy blocks", req_n, 1'b1);
      idle_all();
      svc_req = 1;
      edges(D + 2);
      chk("R3 no dma", req_n, 1'b1);
      idle_all();
      dma_req = 1;
      edges(D + 2);
      chk("R3 no svc", req_n, 1'b1);
      idle_all();

      // Full handshake
      svc_req = 1; dma_req = 1;
      edges(D - 1);
      chk("R4 one edge early", req_n, 1'b1);
      edges(1);
      chk("R5 strobe low", req_n, 1'b0);
      sel_busy_in = 1;
      edges(2);
      prio_in = 1; #1 chk("R6 fwd before ack", prio_out, 1'b1);
      prio_in = 0;
      edges(1);
      prio_in = 1; #1 chk("R6 blocked after ack", prio_out, 1'b0);
      edges(2);
      chk("R7 not yet selected", selected, 1'b0);
      edges(1);
      chk("R7 selected", selected, 1'b1);
      chk("R7 xfer_on", xfer_on, 1'b1);
      chk("R7 req withdrawn", req_n, 1'b1);
      prio_in = 0;
      sel_busy_in = 0;
      edges(D + 4);
      chk("R10 no re-request", req_n, 1'b1);
      chk("R10 still selected", selected, 1'b1);
      svc_req = 0;
      edges(1);
      chk("R8 selected cleared", selected, 1'b0);
      chk("R8 xfer cleared", xfer_on, 1'b0);
      prio_in = 1; #1 chk("R8 pass resumes", prio_out, 1'b1);
      prio_in = 0;
      idle_all();

      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule